// File: doc/BRIEF.md
# Interlaced Field to Progressive Frame Writer

This block takes the active pixels of an interlaced video source and writes them into a progressive frame buffer. Pixels arrive one per cycle, each with a valid qualifier. Two strobes mark the first pixel of a field and the first pixel of a line, and a parity input tells which field is starting. The block tracks the line and column of every pixel. It maps lines of the even field onto even frame rows and lines of the odd field onto odd rows. Each accepted pixel becomes one word write on a memory port with valid/ready handshaking.

A shallow FIFO sits between the position logic and the memory port, so short stalls from memory do not reach the source. The source is never stalled. When the FIFO is full the incoming pixel is dropped and a saturating counter records it. Pixels that fall outside the frame geometry are never written, and they set a sticky overflow flag. Frame geometry, pixel width, FIFO depth and counter width are parameters. The defaults are 720 columns, 240 lines per field (480 frame rows) and 16-bit pixels.

Top module: `field_frame_writer`

## Requirements
- R1: After reset `mem_valid` is 0, `overflow` is 0 and `drop_count` is 0.
- R2: A valid pixel with `in_field_start` high is placed at line 0, column 0 of the field selected by `in_field_odd` (0 = even, 1 = odd). `in_field_start` takes precedence over `in_line_start` on the same pixel.
- R3: A valid pixel with `in_line_start` high and `in_field_start` low is placed at column 0 of the line after the previous pixel's line, in the same field.
- R4: A valid pixel with both strobes low is placed one column to the right of the previous pixel, on the same line.
- R5: The write address is (2 × line + field) × COLS + column, so an even-field line n goes to frame row 2n and an odd-field line n goes to row 2n+1. The data written is the pixel unchanged.
- R6: A pixel at column COLS or beyond, or at line LINES or beyond within its field, is not written. It sets `overflow`, which stays 1 until reset.
- R7: Pixels that arrive after reset and before the first field start are not written, and they set `overflow`.
- R8: An in-range pixel that arrives while the FIFO holds DEPTH entries is discarded and increments `drop_count`, which saturates at its maximum. The column and line tracking still advance past the dropped pixel.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr` and `mem_data` hold their values. Writes leave in pixel arrival order.
- R10: An accepted pixel appears on the memory port on the cycle after it is presented. The port can complete one write per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Pixel present this cycle |
| in_data | input | PIX_W | Pixel value |
| in_line_start | input | 1 | First pixel of a line |
| in_field_start | input | 1 | First pixel of a field |
| in_field_odd | input | 1 | Parity of the field being started (1 = odd) |
| mem_valid | output | 1 | Write request pending |
| mem_addr | output | ADDR_W | Frame-buffer word address |
| mem_data | output | PIX_W | Word to write |
| mem_ready | input | 1 | Memory accepts the pending write |
| overflow | output | 1 | Sticky out-of-geometry pixel flag |
| drop_count | output | CNT_W | Saturating count of pixels lost to a full FIFO |

## Verification
Several properties are checked on every cycle:
- a pending write stays frozen while memory stalls;
- the overflow flag never clears once set;
- the drop counter never decreases;
- every issued address lies inside the frame buffer;
- the flag and the counter change only in a cycle that follows a presented pixel.

Other behaviours depend on sequences of pixels, and only the bench scenarios can show them:
- the row interleaving by field parity;
- the precedence of the field strobe over the line strobe;
- discarding at the right column and line edges;
- rejection before the first field start;
- position tracking that continues across dropped pixels.

// File: rtl/ffw_pkg.sv
// Package: shared types for the field-to-frame writer.
// Assumes: nothing beyond being compiled before the modules that import it.
package ffw_pkg;

    // How an incoming pixel moves the position tracker.
    typedef enum logic [1:0] {
        POS_PIXEL = 2'd0,   // next column on the same line
        POS_LINE  = 2'd1,   // column 0 of the next line
        POS_FIELD = 2'd2    // line 0, column 0 of a new field
    } pos_kind_e;

endpackage

// File: rtl/ffw_pos_tracker.sv
// Module: ffw_pos_tracker
// Works out the field, line and column of each incoming pixel from the
// strobes and the previous pixel's position. It flags whether the pixel lies
// inside the frame geometry and forms its interleaved frame-buffer address.
// Assumes: LINES >= 2 and COLS >= 2. Out-of-range counts saturate one past
// the last legal value. Reset leaves the tracker out of range until the first
// field start.
module ffw_pos_tracker #(
    parameter int COLS   = 720,
    parameter int LINES  = 240,
    parameter int ADDR_W = $clog2(COLS * LINES * 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              field_start,
    input  logic              line_start,
    input  logic              field_odd,
    output logic              in_range,
    output logic [ADDR_W-1:0] pix_addr
);
    import ffw_pkg::*;

    localparam int CW = $clog2(COLS + 1);
    localparam int LW = $clog2(LINES + 1);
    localparam int RW = $clog2(2 * LINES);

    logic [CW-1:0] col_q,  col_d;
    logic [LW-1:0] line_q, line_d;
    logic          field_q, field_d;
    logic [RW-1:0] row;
    pos_kind_e     kind;

    // Classify the pixel; the field strobe outranks the line strobe.
    always_comb begin
        if (field_start)     kind = POS_FIELD;
        else if (line_start) kind = POS_LINE;
        else                 kind = POS_PIXEL;
    end

    // Position of the incoming pixel, with saturating counters.
    always_comb begin
        col_d   = col_q;
        line_d  = line_q;
        field_d = field_q;
        case (kind)
            POS_FIELD: begin
                col_d   = '0;
                line_d  = '0;
                field_d = field_odd;
            end
            POS_LINE: begin
                col_d  = '0;
                line_d = (line_q == LW'(LINES)) ? line_q : line_q + 1'b1;
            end
            default: begin
                col_d = (col_q == CW'(COLS)) ? col_q : col_q + 1'b1;
            end
        endcase
    end

    // Geometry test and interleaved address for the incoming pixel.
    always_comb begin
        in_range = (line_d < LW'(LINES)) && (col_d < CW'(COLS));
        row      = RW'({line_d, field_d});
        pix_addr = ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col_d);
    end

    // Remember the position of the last presented pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q   <= '0;
            line_q  <= LW'(LINES);
            field_q <= 1'b0;
        end else if (pix_valid) begin
            col_q   <= col_d;
            line_q  <= line_d;
            field_q <= field_d;
        end
    end

endmodule

// File: rtl/ffw_fifo.sv
// Module: ffw_fifo
// Register-based first-in first-out queue that holds pending memory writes.
// Assumes: the caller never pushes while full or pops while empty. The head
// entry is presented combinationally from storage.
module ffw_fifo #(
    parameter int W     = 35,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [NW-1:0] count;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Occupancy flags.
    always_comb begin
        not_empty = (count != '0);
        full      = (count == NW'(DEPTH));
        head      = store[rd_ptr];
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Entry storage; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/ffw_sat_counter.sv
// Module: ffw_sat_counter
// Event counter that stops at its all-ones value.
// Assumes: one event per cycle at most.
module ffw_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count events, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                 count <= '0;
        else if (inc && ~&count)    count <= count + 1'b1;
    end

endmodule

// File: rtl/field_frame_writer.sv
// Module: field_frame_writer
// Rebuilds progressive frames from an interlaced pixel stream. Each in-range
// pixel is queued as one memory word write. Out-of-geometry pixels raise a
// sticky flag, and pixels that meet a full queue are counted and discarded.
// Assumes: at most one pixel per cycle. The source cannot be stalled.
// Memory follows valid/ready rules and may stall indefinitely.
module field_frame_writer #(
    parameter int PIX_W  = 16,
    parameter int COLS   = 720,
    parameter int LINES  = 240,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = $clog2(COLS * LINES * 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_data,
    input  logic              in_line_start,
    input  logic              in_field_start,
    input  logic              in_field_odd,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_data,
    input  logic              mem_ready,
    output logic              overflow,
    output logic [CNT_W-1:0]  drop_count
);
    localparam int EW = ADDR_W + PIX_W;

    logic              in_range;
    logic [ADDR_W-1:0] pix_addr;
    logic              q_full, q_not_empty, q_push, q_pop, drop_evt;
    logic [EW-1:0]     q_head;

    ffw_pos_tracker #(
        .COLS   (COLS),
        .LINES  (LINES),
        .ADDR_W (ADDR_W)
    ) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid   (in_valid),
        .field_start (in_field_start),
        .line_start  (in_line_start),
        .field_odd   (in_field_odd),
        .in_range    (in_range),
        .pix_addr    (pix_addr)
    );

    // Route each presented pixel: queue it, drop it, or reject it.
    always_comb begin
        q_push   = in_valid && in_range && !q_full;
        drop_evt = in_valid && in_range &&  q_full;
        q_pop    = q_not_empty && mem_ready;
    end

    ffw_fifo #(
        .W     (EW),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data ({pix_addr, in_data}),
        .pop       (q_pop),
        .head      (q_head),
        .not_empty (q_not_empty),
        .full      (q_full)
    );

    ffw_sat_counter #(
        .W (CNT_W)
    ) u_drops (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop_evt),
        .count (drop_count)
    );

    // Present the queue head on the memory write port.
    always_comb begin
        mem_valid = q_not_empty;
        mem_addr  = q_head[EW-1:PIX_W];
        mem_data  = q_head[PIX_W-1:0];
    end

    // Sticky flag for pixels outside the frame geometry.
    always_ff @(posedge clk) begin
        if (!rst_n)                     overflow <= 1'b0;
        else if (in_valid && !in_range) overflow <= 1'b1;
    end

endmodule

// File: rtl/ffw_checker.sv
// Module: ffw_checker
// Cycle-by-cycle properties of the writer's ports, attached by bind.
// Assumes: the same parameters as the bound writer instance.
module ffw_checker #(
    parameter int PIX_W  = 16,
    parameter int COLS   = 720,
    parameter int LINES  = 240,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [PIX_W-1:0]  mem_data,
    input logic              mem_ready,
    input logic              overflow,
    input logic [CNT_W-1:0]  drop_count
);
    localparam logic [ADDR_W:0] WORDS = (ADDR_W + 1)'(COLS * LINES * 2);

    // R9: a stalled write keeps its request, address and data
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R6: overflow never clears without reset
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R6: overflow rises only after a presented pixel
    p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(overflow));

    // R8: drop count never decreases
    p_drop_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> drop_count >= $past(drop_count));

    // R8: drop count changes only after a presented pixel
    p_drop_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(drop_count));

    // R5: every write lands inside the frame buffer
    p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> {1'b0, mem_addr} < WORDS);

endmodule

bind field_frame_writer ffw_checker #(
    .PIX_W  (PIX_W),
    .COLS   (COLS),
    .LINES  (LINES),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_ffw_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .mem_ready  (mem_ready),
    .overflow   (overflow),
    .drop_count (drop_count)
);

// File: tb/field_frame_writer_bench.sv
`timescale 1ns/1ps
// Bench for field_frame_writer: a vector table for placement, then directed
// tests for reset, geometry edges, pre-sync rejection and backpressure.
module field_frame_writer_bench;
    localparam int PIX_W = 16;
    localparam int AW    = 19;
    localparam int CW    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_ls = 1'b0, in_fs = 1'b0, in_odd = 1'b0;
    logic [PIX_W-1:0] in_data = '0;
    logic             mem_valid, mem_ready = 1'b0, overflow;
    logic [AW-1:0]    mem_addr;
    logic [PIX_W-1:0] mem_data;
    logic [CW-1:0]    drop_count;

    int tests = 0, fails = 0;
    int wcnt = 0, ord_err = 0;
    logic [AW-1:0] last_addr = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    field_frame_writer #(.CNT_W(CW)) u_field_frame_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_line_start(in_ls), .in_field_start(in_fs), .in_field_odd(in_odd),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ready(mem_ready), .overflow(overflow), .drop_count(drop_count)
    );

    // Completed writes: count, last address, order against a 0,1,2.. run.
    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 0; ord_err <= 0;
        end else if (mem_valid && mem_ready) begin
            wcnt      <= wcnt + 1;
            last_addr <= mem_addr;
            if (int'(mem_addr) != wcnt) ord_err <= ord_err + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pix(input bit fs, input bit ls, input bit odd, input logic [PIX_W-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_fs = fs; in_ls = ls; in_odd = odd; in_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_fs = 1'b0; in_ls = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0; mem_ready = 1'b0; rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    // {field_start, line_start, odd, data, expected address}
    localparam int NV = 10;
    localparam logic [37:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 16'hA000, 19'd0},     // R2 even field origin
        {1'b0, 1'b0, 1'b0, 16'hA001, 19'd1},     // R4 next column
        {1'b0, 1'b1, 1'b0, 16'hA002, 19'd1440},  // R3 even line 1 -> row 2
        {1'b0, 1'b0, 1'b0, 16'hA003, 19'd1441},  // R4
        {1'b1, 1'b0, 1'b1, 16'hB000, 19'd720},   // R2 odd field -> row 1
        {1'b0, 1'b0, 1'b0, 16'hB001, 19'd721},   // R4
        {1'b0, 1'b1, 1'b0, 16'hB002, 19'd2160},  // R3 odd line 1 -> row 3
        {1'b0, 1'b1, 1'b0, 16'hB003, 19'd3600},  // R3 odd line 2 -> row 5
        {1'b1, 1'b0, 1'b0, 16'hC000, 19'd0},     // R2 back to even field
        {1'b1, 1'b1, 1'b1, 16'hC001, 19'd720}    // R2 field strobe wins
    };

    initial begin
        do_reset();
        idle(1);
        chk(mem_valid == 1'b0, "R1 mem_valid", mem_valid, 0);
        chk(overflow == 1'b0, "R1 overflow", overflow, 0);
        chk(drop_count == '0, "R1 drop_count", drop_count, 0);

        // R7: pixels before the first field start are rejected
        pix(1'b0, 1'b0, 1'b0, 16'h1111);
        pix(1'b0, 1'b1, 1'b0, 16'h2222);
        idle(2);
        chk(mem_valid == 1'b0, "R7 no write", mem_valid, 0);
        chk(overflow == 1'b1, "R7 overflow", overflow, 1);

        // Table: one pixel at a time, check placement and single-cycle latency
        do_reset();
        for (int v = 0; v < NV; v++) begin
            pix(VEC[v][37], VEC[v][36], VEC[v][35], VEC[v][34:19]);
            idle(1);
            chk(mem_valid == 1'b1, "R10 write pending", mem_valid, 1);
            chk(mem_addr == VEC[v][18:0], "R5 address", mem_addr, VEC[v][18:0]);
            chk(mem_data == VEC[v][34:19], "R5 data", mem_data, VEC[v][34:19]);
            mem_ready = 1'b1;
            @(negedge clk);
            mem_ready = 1'b0;
            chk(mem_valid == 1'b0, "R10 write retired", mem_valid, 0);
        end
        chk(overflow == 1'b0, "R6 no false overflow", overflow, 0);

        // R6: column edge, 721 pixels on one line
        do_reset();
        mem_ready = 1'b1;
        pix(1'b1, 1'b0, 1'b0, 16'h0);
        for (int c = 1; c <= 720; c++) pix(1'b0, 1'b0, 1'b0, PIX_W'(c));
        idle(4);
        chk(wcnt == 720, "R6 column writes", wcnt, 720);
        chk(ord_err == 0, "R10 column order", ord_err, 0);
        chk(last_addr == 19'd719, "R6 last column", last_addr, 719);
        chk(overflow == 1'b1, "R6 column overflow", overflow, 1);

        // R6: line edge, 241 lines in the even field
        do_reset();
        mem_ready = 1'b1;
        pix(1'b1, 1'b0, 1'b0, 16'h0);
        for (int l = 1; l < 240; l++) pix(1'b0, 1'b1, 1'b0, PIX_W'(l));
        idle(3);
        chk(overflow == 1'b0, "R6 line 239 legal", overflow, 0);
        pix(1'b0, 1'b1, 1'b0, 16'hFFFF);
        idle(3);
        chk(wcnt == 240, "R6 line writes", wcnt, 240);
        chk(last_addr == 19'd344160, "R3 last row 478", last_addr, 344160);
        chk(overflow == 1'b1, "R6 line overflow", overflow, 1);

        // R8/R9: backpressure with an 8-deep queue
        do_reset();
        pix(1'b1, 1'b0, 1'b0, 16'h0);
        for (int c = 1; c < 12; c++) pix(1'b0, 1'b0, 1'b0, PIX_W'(c));
        idle(1);
        chk(drop_count == 3'd4, "R8 drops counted", drop_count, 4);
        chk(mem_valid && mem_addr == '0, "R9 head held", mem_addr, 0);
        idle(3);
        chk(mem_valid && mem_addr == '0 && mem_data == '0, "R9 stall stable", mem_addr, 0);
        mem_ready = 1'b1;
        idle(10);
        chk(wcnt == 8, "R8 queued writes", wcnt, 8);
        chk(ord_err == 0, "R9 order", ord_err, 0);
        pix(1'b0, 1'b0, 1'b0, 16'h00CC);
        idle(3);
        chk(last_addr == 19'd12, "R8 tracking past drops", last_addr, 12);
        chk(overflow == 1'b0, "R8 drops not overflow", overflow, 0);

        // R8: counter saturation
        do_reset();
        pix(1'b1, 1'b0, 1'b0, 16'h0);
        for (int c = 1; c < 20; c++) pix(1'b0, 1'b0, 1'b0, PIX_W'(c));
        idle(1);
        chk(drop_count == 3'd7, "R8 saturation", drop_count, 7);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #600000;
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule